// File: doc/BRIEF.md
# Two-Class Memory Request Arbiter

This block merges memory requests from a set of display clients onto a single downstream request port. Each client presents one request at a time on a valid/ready handshake. The request carries an address, a write flag and a class tag. High-class requests are isochronous plane fetches. They are admitted into a small internal queue, and that queue only starts to drain once it has built up a programmable number of entries. Low-class requests are writes, or occasional reads, from capture, compression and state engines. The arbiter takes them straight from the clients. A round-robin pointer shares the port between them, and each client may keep it only for a bounded back-to-back burst.

Static configuration inputs carry encoded fields. These set the queue watermark, the burst length of each low-class client, the read caps of both classes and the credit floor. A credit-level input reports how many transaction credits the memory side currently has. High-class traffic is held back while that level is below the floor. Completions come back on a strobe tagged with their class. Two in-flight counters use these strobes to bound the outstanding reads of each class.

Top module: `tca_arb`

## Requirements
- R1: After reset, with no client requesting, `dn_valid` is 0 and every `req_ready` bit is 0.
- R2: The high-class queue offers nothing downstream until it holds at least `cfg_hpq_wm + 1` entries (field 0..7 means 1..8 entries), and entries leave in arrival order.
- R3: Once draining has started, the high-class queue keeps draining until it is empty, even after it falls below the watermark.
- R4: A high-class request is offered only when `credit_level >= 8 << cfg_credit_wm`. Field values 0, 1, 2 and 3 give floors of 8, 16, 32 and 64.
- R5: When an eligible high-class request and an eligible low-class request exist in the same cycle, and no offer is pending, the high-class request is offered (`dn_hp` = 1).
- R6: Low-class grants rotate round-robin and search from the client after the last granted one. After reset the search starts at client 0.
- R7: A low-class client keeps the port for at most `2^f` back-to-back grants, where `f` is its 2-bit field at bit offset `2*i` of `cfg_b2b`. After that the arbiter re-arbitrates among the clients.
- R8: For client index `EXT_ID` only, field value 3 means a burst of 16 grants. For every other client, field value 3 means 8 grants.
- R9: Outstanding low-class reads never exceed `cfg_lp_rd + 1`. Low-class writes are not held back by this cap.
- R10: Outstanding high-class reads never exceed `2^(7 - cfg_hp_rd)`, which gives 128, 64, 32 or 16.
- R11: An in-flight counter increments when a read of its class is accepted downstream and decrements on a `cpl_valid` strobe whose `cpl_hp` matches its class. It never wraps below zero or above its maximum.
- R12: The burst limit is sampled when a burst starts. A change of `cfg_b2b` during a burst takes effect only at that client's next burst.
- R13: Once `dn_valid` is high and `dn_ready` is low, the same request (address, source, class) stays offered until it is accepted.
- R14: At most one high-class request is admitted per cycle: the lowest-index requesting client, and only while the queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | N | Per-client request valid |
| req_hp | input | N | Per-client class tag, 1 = high class |
| req_wr | input | N | Per-client write flag, 1 = write |
| req_addr | input | N*AW | Per-client address, client i at bits i*AW +: AW |
| req_ready | output | N | Per-client request accepted this cycle |
| cfg_hpq_wm | input | 3 | High-class queue watermark, entries = field + 1 |
| cfg_b2b | input | 2*N | Per-client burst field, client i at bits 2*i +: 2 |
| cfg_lp_rd | input | 2 | Low-class read cap, field + 1 |
| cfg_hp_rd | input | 2 | High-class read cap, 2^(7 - field) |
| cfg_credit_wm | input | 2 | Credit floor for high class, 8 << field |
| credit_level | input | CRW | Currently available transaction credits |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_addr | output | AW | Downstream address |
| dn_wr | output | 1 | Downstream write flag |
| dn_hp | output | 1 | Downstream class, 1 = high |
| dn_src | output | SW | Index of the client that issued the request |
| cpl_valid | input | 1 | One read has completed |
| cpl_hp | input | 1 | Class of the completed read |

## Verification
The embedded properties assume several things about the inputs. Clients hold their request steady until `req_ready` is seen. The configuration fields, and in particular the read caps, do not change while reads are outstanding. `cpl_valid` is never pulsed for a class that has no read in flight, except in the one scenario that deliberately tests saturation at zero. The directed bench programs every field before it raises any request and drops a client's valid in the cycle after that client's grant. Its only configuration edit in flight is the burst field changed mid-burst, because that change is itself the behaviour under test.

// File: rtl/tca_pkg.sv
package tca_pkg;

  // burst length for a low-class client; the extended client doubles code 3
  function automatic logic [4:0] b2b_limit(input logic [1:0] f, input logic ext);
    if (ext && (f == 2'd3)) return 5'd16;
    return 5'd1 << f;
  endfunction

  // cap on outstanding high-class reads: 128 >> field
  function automatic logic [7:0] hp_rd_limit(input logic [1:0] f);
    return 8'd1 << (3'd7 - {1'b0, f});
  endfunction

  // cap on outstanding low-class reads: field + 1
  function automatic logic [2:0] lp_rd_limit(input logic [1:0] f);
    return {1'b0, f} + 3'd1;
  endfunction

  // credit floor that gates high-class traffic
  function automatic logic [6:0] credit_floor(input logic [1:0] f);
    return 7'd8 << f;
  endfunction

  // queue fill level that opens the high-class drain
  function automatic logic [3:0] hpq_fill(input logic [2:0] f);
    return {1'b0, f} + 4'd1;
  endfunction

endpackage

// File: rtl/tca_hp_queue.sv
module tca_hp_queue #(
  parameter int AW    = 16,
  parameter int SW    = 2,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          push_wr,
  input  logic [SW-1:0] push_src,
  input  logic          pop,
  input  logic [2:0]    wm_field,
  output logic [AW-1:0] head_addr,
  output logic          head_wr,
  output logic [SW-1:0] head_src,
  output logic          head_valid,
  output logic          full,
  output logic          open
);
  import tca_pkg::*;

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_mem [DEPTH];
  logic          wr_mem   [DEPTH];
  logic [SW-1:0] src_mem  [DEPTH];

  logic [PW-1:0] rd_q, rd_d, wp_q, wp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          drain_q, drain_d;

  // storage: written only on push, no reset needed
  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wp_q] <= push_addr;
      wr_mem[wp_q]   <= push_wr;
      src_mem[wp_q]  <= push_src;
    end
  end

  assign head_addr  = addr_mem[rd_q];
  assign head_wr    = wr_mem[rd_q];
  assign head_src   = src_mem[rd_q];
  assign head_valid = (cnt_q != '0);
  assign full       = (int'(cnt_q) == DEPTH);
  assign open       = drain_q | (int'(cnt_q) >= int'(hpq_fill(wm_field)));

  always_comb begin
    rd_d    = rd_q;
    wp_d    = wp_q;
    cnt_d   = cnt_q;
    if (push) wp_d = wp_q + 1'b1;
    if (pop)  rd_d = rd_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    if (pop && !push) cnt_d = cnt_q - 1'b1;
    drain_d = open && (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wp_q    <= '0;
      cnt_q   <= '0;
      drain_q <= 1'b0;
    end else begin
      rd_q    <= rd_d;
      wp_q    <= wp_d;
      cnt_q   <= cnt_d;
      drain_q <= drain_d;
    end
  end

  // R2
  pop_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (open && head_valid));

  // R14
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

endmodule

// File: rtl/tca_lp_arb.sv
module tca_lp_arb #(
  parameter int N   = 4,
  parameter int SW  = 2,
  parameter int EXT = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   elig,
  input  logic [2*N-1:0] b2b_field,
  input  logic           commit,
  input  logic [SW-1:0]  commit_idx,
  output logic [SW-1:0]  pick,
  output logic           any
);
  import tca_pkg::*;

  localparam logic [SW-1:0] EXT_ID   = SW'(EXT);
  localparam logic [SW-1:0] LAST_ID  = SW'(N - 1);

  logic [SW-1:0] owner_q, owner_d, rr_pick;
  logic [4:0]    cnt_q, cnt_d, lim_q, lim_d;
  logic          burst_q, burst_d;
  logic          cont, found;
  int            idx;

  assign any  = |elig;
  assign cont = burst_q && elig[owner_q] && (cnt_q < lim_q);

  // round-robin search starting after the current owner
  always_comb begin
    found   = 1'b0;
    rr_pick = owner_q;
    idx     = 0;
    for (int i = 1; i <= N; i++) begin
      idx = (int'(owner_q) + i) % N;
      if (!found && elig[idx]) begin
        rr_pick = idx[SW-1:0];
        found   = 1'b1;
      end
    end
  end

  assign pick = cont ? owner_q : rr_pick;

  always_comb begin
    owner_d = owner_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    burst_d = burst_q && elig[owner_q];
    if (commit) begin
      if (burst_q && (commit_idx == owner_q) && (cnt_q < lim_q)) begin
        cnt_d   = cnt_q + 5'd1;
        burst_d = 1'b1;
      end else begin
        owner_d = commit_idx;
        cnt_d   = 5'd1;
        lim_d   = b2b_limit(b2b_field[{commit_idx, 1'b0} +: 2], commit_idx == EXT_ID);
        burst_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= LAST_ID;
      cnt_q   <= '0;
      lim_q   <= 5'd1;
      burst_q <= 1'b0;
    end else begin
      owner_q <= owner_d;
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
      burst_q <= burst_d;
    end
  end

  // R7
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_q |-> ((cnt_q != 5'd0) && (cnt_q <= lim_q)));

  // R6
  pick_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> elig[pick]);

endmodule

// File: rtl/tca_inflight.sv
module tca_inflight #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec && (cnt_q != TOP)) cnt_d = cnt_q + 1'b1;
    if (dec && !inc && (cnt_q != '0))  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && !inc) |=> (cnt_q == '0));

endmodule

// File: rtl/tca_arb.sv
module tca_arb #(
  parameter int N     = 4,
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  parameter int EXT   = 3,
  parameter int CRW   = 7,
  localparam int SW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req_valid,
  input  logic [N-1:0]   req_hp,
  input  logic [N-1:0]   req_wr,
  input  logic [N*AW-1:0] req_addr,
  output logic [N-1:0]   req_ready,
  input  logic [2:0]     cfg_hpq_wm,
  input  logic [2*N-1:0] cfg_b2b,
  input  logic [1:0]     cfg_lp_rd,
  input  logic [1:0]     cfg_hp_rd,
  input  logic [1:0]     cfg_credit_wm,
  input  logic [CRW-1:0] credit_level,
  output logic           dn_valid,
  input  logic           dn_ready,
  output logic [AW-1:0]  dn_addr,
  output logic           dn_wr,
  output logic           dn_hp,
  output logic [SW-1:0]  dn_src,
  input  logic           cpl_valid,
  input  logic           cpl_hp
);
  import tca_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // high-class admission: lowest index first
  logic [N-1:0]  hp_req;
  logic [SW-1:0] admit_idx;
  logic          push;
  logic          q_full, q_open, q_valid, q_wr;
  logic [AW-1:0] q_addr;
  logic [SW-1:0] q_src;
  logic          pop;

  assign hp_req = req_valid & req_hp;

  always_comb begin
    admit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hp_req[i]) admit_idx = SW'(i);
    end
  end

  assign push = (|hp_req) && !q_full;

  tca_hp_queue #(.AW(AW), .SW(SW), .DEPTH(DEPTH)) u_hpq (
    .clk        (clk),
    .rst_n      (rst_q),
    .push       (push),
    .push_addr  (req_addr[int'(admit_idx)*AW +: AW]),
    .push_wr    (req_wr[admit_idx]),
    .push_src   (admit_idx),
    .pop        (pop),
    .wm_field   (cfg_hpq_wm),
    .head_addr  (q_addr),
    .head_wr    (q_wr),
    .head_src   (q_src),
    .head_valid (q_valid),
    .full       (q_full),
    .open       (q_open)
  );

  // in-flight read tracking per class
  logic [7:0] hp_cnt;
  logic [2:0] lp_cnt;
  logic       accept, use_hp;
  logic       hp_inc, lp_inc, hp_dec, lp_dec;

  assign hp_inc = accept && use_hp && !dn_wr;
  assign lp_inc = accept && !use_hp && !dn_wr;
  assign hp_dec = cpl_valid && cpl_hp;
  assign lp_dec = cpl_valid && !cpl_hp;

  tca_inflight #(.W(8)) u_hp_cnt (
    .clk (clk), .rst_n (rst_q), .inc (hp_inc), .dec (hp_dec), .cnt (hp_cnt)
  );

  tca_inflight #(.W(3)) u_lp_cnt (
    .clk (clk), .rst_n (rst_q), .inc (lp_inc), .dec (lp_dec), .cnt (lp_cnt)
  );

  // eligibility of each class
  logic         credit_ok, hp_ok, lp_rd_room;
  logic [N-1:0] lp_elig;

  assign credit_ok  = int'(credit_level) >= int'(credit_floor(cfg_credit_wm));
  assign hp_ok      = q_open && q_valid && credit_ok &&
                      (q_wr || (hp_cnt < hp_rd_limit(cfg_hp_rd)));
  assign lp_rd_room = lp_cnt < lp_rd_limit(cfg_lp_rd);
  assign lp_elig    = req_valid & ~req_hp & (req_wr | {N{lp_rd_room}});

  logic [SW-1:0] lp_pick, lp_idx;
  logic          lp_any, lp_commit;

  tca_lp_arb #(.N(N), .SW(SW), .EXT(EXT)) u_lp (
    .clk        (clk),
    .rst_n      (rst_q),
    .elig       (lp_elig),
    .b2b_field  (cfg_b2b),
    .commit     (lp_commit),
    .commit_idx (lp_idx),
    .pick       (lp_pick),
    .any        (lp_any)
  );

  // offer selection with hold while downstream stalls
  logic          lock_q, lock_d, lock_hp_q, lock_hp_d;
  logic [SW-1:0] lock_idx_q, lock_idx_d;
  logic          offer;

  always_comb begin
    if (lock_q) begin
      use_hp = lock_hp_q;
      lp_idx = lock_idx_q;
      offer  = 1'b1;
    end else begin
      use_hp = hp_ok;
      lp_idx = lp_pick;
      offer  = hp_ok || lp_any;
    end
  end

  assign dn_valid  = offer;
  assign dn_hp     = use_hp;
  assign dn_addr   = use_hp ? q_addr : req_addr[int'(lp_idx)*AW +: AW];
  assign dn_wr     = use_hp ? q_wr : req_wr[lp_idx];
  assign dn_src    = use_hp ? q_src : lp_idx;

  assign accept    = offer && dn_ready;
  assign pop       = accept && use_hp;
  assign lp_commit = accept && !use_hp;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ready
      assign req_ready[g] = (push && (admit_idx == SW'(g))) ||
                            (lp_commit && (lp_idx == SW'(g)));
    end
  endgenerate

  always_comb begin
    lock_d     = offer && !dn_ready;
    lock_hp_d  = lock_hp_q;
    lock_idx_d = lock_idx_q;
    if (lock_d) begin
      lock_hp_d  = use_hp;
      lock_idx_d = lp_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      lock_q     <= 1'b0;
      lock_hp_q  <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= lock_d;
      lock_hp_q  <= lock_hp_d;
      lock_idx_q <= lock_idx_d;
    end
  end

  // R13
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) &&
                                 $stable(dn_src) && $stable(dn_hp)));

  // R10
  hp_cap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (dn_valid && dn_ready && dn_hp && !dn_wr) |-> (hp_cnt < hp_rd_limit(cfg_hp_rd)));

  // R9
  lp_cap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (dn_valid && dn_ready && !dn_hp && !dn_wr) |-> (lp_cnt < lp_rd_limit(cfg_lp_rd)));

  // R14
  admit_one_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(req_ready & req_hp));

  // R4
  credit_gate_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (dn_valid && dn_hp && !lock_q) |->
      (int'(credit_level) >= int'(credit_floor(cfg_credit_wm))));

endmodule

// File: tb/test_tca_arb.sv
module test_tca_arb;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int SW = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   rv, rh, rw;
  logic [N*AW-1:0] ra;
  logic [N-1:0]   req_ready;
  logic [2:0]     cfg_wm;
  logic [2*N-1:0] cfg_b2b;
  logic [1:0]     cfg_lp_rd, cfg_hp_rd, cfg_cr;
  logic [6:0]     credit;
  logic           dn_valid, dn_ready, dn_wr, dn_hp;
  logic [AW-1:0]  dn_addr;
  logic [SW-1:0]  dn_src;
  logic           cpl_valid, cpl_hp;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  tca_arb #(.N(N), .AW(AW), .DEPTH(8), .EXT(3), .CRW(7)) i_tca_arb (
    .clk (clk), .rst_n (rst_n),
    .req_valid (rv), .req_hp (rh), .req_wr (rw), .req_addr (ra),
    .req_ready (req_ready),
    .cfg_hpq_wm (cfg_wm), .cfg_b2b (cfg_b2b), .cfg_lp_rd (cfg_lp_rd),
    .cfg_hp_rd (cfg_hp_rd), .cfg_credit_wm (cfg_cr), .credit_level (credit),
    .dn_valid (dn_valid), .dn_ready (dn_ready), .dn_addr (dn_addr),
    .dn_wr (dn_wr), .dn_hp (dn_hp), .dn_src (dn_src),
    .cpl_valid (cpl_valid), .cpl_hp (cpl_hp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input int i, input logic v, input logic h, input logic w,
                       input logic [AW-1:0] a);
    rv[i] = v; rh[i] = h; rw[i] = w; ra[i*AW +: AW] = a;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rv = '0; rh = '0; rw = '0; ra = '0;
    cfg_wm = 3'd0; cfg_b2b = '0; cfg_lp_rd = 2'd3; cfg_hp_rd = 2'd0;
    cfg_cr = 2'd0; credit = 7'd63; dn_ready = 1'b1;
    cpl_valid = 1'b0; cpl_hp = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk); #1;
    chk("R1 dn_valid", 32'(dn_valid), 0);
    chk("R1 req_ready", 32'(req_ready), 0);
  endtask

  task automatic t_watermark();
    do_reset();
    cfg_wm = 3'd2;
    @(negedge clk);
    drive(1, 1, 1, 0, 16'h1111); drive(2, 1, 1, 0, 16'h2222); #1;
    chk("R14 lowest admitted", 32'(req_ready), 32'b0010);
    chk("R2 empty queue", 32'(dn_valid), 0);
    @(negedge clk); drive(1, 0, 0, 0, 0); #1;
    chk("R14 next admitted", 32'(req_ready), 32'b0100);
    chk("R2 one entry", 32'(dn_valid), 0);
    @(negedge clk); drive(2, 0, 0, 0, 0); drive(0, 1, 1, 0, 16'h0a0a); #1;
    chk("R2 two entries", 32'(dn_valid), 0);
    @(negedge clk); drive(0, 0, 0, 0, 0); #1;
    chk("R2 watermark reached", 32'(dn_valid), 1);
    chk("R2 first in order", 32'(dn_addr), 32'h1111);
    @(negedge clk); #1;
    chk("R3 below watermark continues", 32'(dn_valid), 1);
    chk("R3 second in order", 32'(dn_addr), 32'h2222);
    @(negedge clk); #1;
    chk("R3 third in order", 32'(dn_addr), 32'h0a0a);
    @(negedge clk); #1;
    chk("R3 empty stops", 32'(dn_valid), 0);
  endtask

  task automatic t_credit();
    do_reset();
    cfg_cr = 2'd1; credit = 7'd15;
    @(negedge clk); drive(0, 1, 1, 0, 16'h0100); #1;
    @(negedge clk); drive(0, 0, 0, 0, 0); #1;
    chk("R4 below floor", 32'(dn_valid), 0);
    @(negedge clk); credit = 7'd16; #1;
    chk("R4 at floor", 32'(dn_valid), 1);
    chk("R4 at floor addr", 32'(dn_addr), 32'h0100);
  endtask

  task automatic t_prio();
    do_reset();
    @(negedge clk); drive(0, 1, 1, 0, 16'h00aa); drive(2, 1, 0, 1, 16'h0c01); #1;
    chk("R5 low class while queue empty", 32'(dn_src), 2);
    chk("R5 readies", 32'(req_ready), 32'b0101);
    @(negedge clk); drive(0, 0, 0, 0, 0); drive(2, 1, 0, 1, 16'h0c02); #1;
    chk("R5 high class wins", 32'(dn_hp), 1);
    chk("R5 high class source", 32'(dn_src), 0);
    chk("R5 low class waits", 32'(req_ready[2]), 0);
    @(negedge clk); #1;
    chk("R5 low class after", 32'(dn_addr), 32'h0c02);
  endtask

  task automatic t_rr();
    int exp_seq[5] = '{0, 1, 3, 0, 1};
    do_reset();
    @(negedge clk);
    drive(0, 1, 0, 1, 16'h10); drive(1, 1, 0, 1, 16'h11); drive(3, 1, 0, 1, 16'h13);
    #1;
    for (int k = 0; k < 5; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      chk("R6 rotation", 32'(dn_src), 32'(exp_seq[k]));
    end
  endtask

  task automatic t_burst();
    int exp_seq[8] = '{1, 1, 1, 1, 2, 1, 2, 1};
    do_reset();
    cfg_b2b[3:2] = 2'd2;
    @(negedge clk);
    drive(1, 1, 0, 1, 16'h21); drive(2, 1, 0, 1, 16'h22);
    #1;
    for (int k = 0; k < 8; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      if (k < 5) chk("R7 burst of four", 32'(dn_src), 32'(exp_seq[k]));
      else       chk("R12 new limit next burst", 32'(dn_src), 32'(exp_seq[k]));
      if (k == 1) cfg_b2b[3:2] = 2'd0;
    end
  endtask

  task automatic t_ext(input int idx, input int len);
    do_reset();
    cfg_b2b[idx*2 +: 2] = 2'd3;
    @(negedge clk);
    drive(0, 1, 0, 1, 16'h30); drive(idx, 1, 0, 1, 16'h33);
    #1;
    for (int k = 0; k < len + 2; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      chk("R8 code 3 burst", 32'(dn_src),
          ((k == 0) || (k == len + 1)) ? 32'd0 : 32'(idx));
    end
  endtask

  task automatic t_lp_cap();
    do_reset();
    cfg_lp_rd = 2'd1;
    @(negedge clk); drive(0, 1, 0, 0, 16'h20); #1;
    chk("R9 first read", 32'(dn_valid), 1);
    @(negedge clk); #1;
    chk("R9 second read", 32'(dn_valid), 1);
    @(negedge clk); #1;
    chk("R9 cap reached", 32'(dn_valid), 0);
    @(negedge clk); drive(1, 1, 0, 1, 16'h21); #1;
    chk("R9 write not capped", 32'(dn_src), 1);
    @(negedge clk); drive(1, 0, 0, 0, 0); cpl_valid = 1'b1; cpl_hp = 1'b0; #1;
    chk("R11 before completion lands", 32'(dn_valid), 0);
    @(negedge clk); cpl_valid = 1'b0; #1;
    chk("R11 completion frees slot", 32'(dn_valid), 1);
    chk("R11 freed slot source", 32'(dn_src), 0);
    do_reset();
    cfg_lp_rd = 2'd0;
    @(negedge clk); cpl_valid = 1'b1; cpl_hp = 1'b0;
    @(negedge clk);
    @(negedge clk); cpl_valid = 1'b0; drive(0, 1, 0, 0, 16'h40); #1;
    chk("R11 no wrap below zero", 32'(dn_valid), 1);
    @(negedge clk); #1;
    chk("R11 single slot used", 32'(dn_valid), 0);
  endtask

  task automatic t_hp_cap();
    int acc = 0;
    do_reset();
    cfg_hp_rd = 2'd3;
    @(negedge clk); drive(0, 1, 1, 0, 16'h0300);
    for (int k = 0; k < 40; k++) begin
      #1;
      if (dn_valid && dn_ready) acc++;
      @(negedge clk);
    end
    chk("R10 sixteen reads", 32'(acc), 16);
    cpl_valid = 1'b1; cpl_hp = 1'b1; #1;
    chk("R10 still capped", 32'(dn_valid), 0);
    @(negedge clk); cpl_valid = 1'b0; #1;
    chk("R11 high class slot freed", 32'(dn_valid), 1);
    chk("R11 high class offer", 32'(dn_hp), 1);
  endtask

  task automatic t_hold();
    do_reset();
    dn_ready = 1'b0;
    @(negedge clk); drive(2, 1, 0, 1, 16'h0c0c); drive(0, 1, 1, 0, 16'h00f0); #1;
    chk("R13 offer shown", 32'(dn_src), 2);
    chk("R13 only admission ready", 32'(req_ready), 32'b0001);
    @(negedge clk); drive(0, 0, 0, 0, 0); #1;
    chk("R13 held over high class", 32'(dn_hp), 0);
    chk("R13 held source", 32'(dn_src), 2);
    chk("R13 held address", 32'(dn_addr), 32'h0c0c);
    @(negedge clk); dn_ready = 1'b1; #1;
    chk("R13 accepted", 32'(req_ready[2]), 1);
    @(negedge clk); drive(2, 0, 0, 0, 0); #1;
    chk("R13 high class follows", 32'(dn_hp), 1);
  endtask

  initial begin
    t_reset();
    t_watermark();
    t_credit();
    t_prio();
    t_rr();
    t_burst();
    t_ext(3, 16);
    t_ext(2, 8);
    t_lp_cap();
    t_hp_cap();
    t_hold();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule